// File: doc/BRIEF.md
# Masked-Write GPIO Register Bank

This block controls 32 general-purpose pins through a small word-addressed register bus. The pins form two halves of sixteen. Each half has a direction register and an output register of its own, at separate addresses. A write to any of those four registers carries a per-bit enable in its upper halfword and new bit values in its lower halfword. Software can therefore set, clear or change any subset of pins in one bus write, with no read-modify-write and no race between two agents that share the bank.

Each pin has an output-enable line and an output-value line for the pad. A pin set to output drives its stored output bit. A pin set to input is released, and its value line is held low. The pad levels pass through a two-stage synchroniser and can be read as one 32-bit input word. Reads are registered: the bus read data updates on the edge that accepts the read and holds until the next read.

Word addresses: 0 is the input word, 1 is the low output register, 2 is the low direction register, 3 is the high output register, and 4 is the high direction register. Addresses 5 to 7 are unmapped.

Top module: `gpio_masked_bank`

## Requirements
- R1: While reset is asserted and after reset, with no writes yet, every direction bit and output bit is 0, so `pin_oe` and `pin_out` are all 0 and `bus_rdata` is 0.
- R2: A write (`bus_sel`=1, `bus_we`=1) to address 1, 2, 3 or 4 uses `bus_wdata[31:16]` as a per-bit enable and `bus_wdata[15:0]` as data. Bit i of the target register takes data bit i when enable bit i is 1 and keeps its value otherwise. An enabled bit with data 0 is cleared, and an enabled bit with data 1 is set.
- R3: A write whose enable halfword is zero changes no register and no pin. Without a write, the pins hold their state.
- R4: When a pin's direction bit is 1, `pin_oe` for that pin is 1 and `pin_out` shows its output bit. When the direction bit is 0, `pin_oe` and `pin_out` are 0 for that pin. The change takes effect right after the clock edge that accepts the write.
- R5: Bit n of the low registers (addresses 1 and 2) controls pin n. Bit n of the high registers (addresses 3 and 4) controls pin 16+n.
- R6: A read (`bus_sel`=1, `bus_we`=0) of address 1 to 4 returns that register's 16-bit state in bits 15:0 and zeros in bits 31:16. `bus_rdata` loads on the edge that accepts the read and holds until the next read.
- R7: A read of address 0 returns all 32 synchronised pin levels, with bit n being pin n. A level applied before clock edge k is returned by a read accepted at edge k+2 and not by a read at edge k+1.
- R8: A write to address 0 or to an unmapped address (5 to 7) changes nothing. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write word: enable halfword in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables, 1 = drive |

## Verification
A pin edge and a read of the input word can fall in the same cycle. The bench applies a new pad level in the same half-cycle that it issues an input read. It expects the old level from that read and from the next one, and the new level only from the third read. A write and an unrelated pin change can also meet. Random writes, with enable halfwords that are zero, full or sparse, are mixed with random pad changes. After each write, the bench compares `pin_oe` and `pin_out` against a model that merges each write's enable and data into its copy of the registers.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned ADDR_W     = 3;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_INPUT = 2'd1,
    KIND_OUT   = 2'd2,
    KIND_DIR   = 2'd3
  } reg_kind_e;

  localparam logic [ADDR_W-1:0] ADDR_INPUT = '0;

  function automatic logic [ADDR_W-1:0] out_addr(input int unsigned half);
    return ADDR_W'(1 + 2 * half);
  endfunction

  function automatic logic [ADDR_W-1:0] dir_addr(input int unsigned half);
    return ADDR_W'(2 + 2 * half);
  endfunction
endpackage

// File: rtl/gpio_reset_sync.sv
module gpio_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
(
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_HALVES-1:0] wr_out,
  output logic [NUM_HALVES-1:0] wr_dir,
  output logic                  rd_strobe
);
  logic is_write;
  assign is_write  = bus_sel & bus_we;
  assign rd_strobe = bus_sel & ~bus_we;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half_dec
    assign wr_out[h] = is_write && (bus_addr == out_addr(h));
    assign wr_dir[h] = is_write && (bus_addr == dir_addr(h));
  end
endmodule

// File: rtl/gpio_half_regs.sv
module gpio_half_regs #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_out,
  input  logic              wr_dir,
  input  logic [HALF_W-1:0] wen,
  input  logic [HALF_W-1:0] wval,
  output logic [HALF_W-1:0] out_q,
  output logic [HALF_W-1:0] dir_q
);
  logic [HALF_W-1:0] out_d, dir_d;
  logic              out_ce, dir_ce;

  function automatic logic [HALF_W-1:0] merge(
    input logic [HALF_W-1:0] cur,
    input logic [HALF_W-1:0] en,
    input logic [HALF_W-1:0] val
  );
    return (cur & ~en) | (val & en);
  endfunction

  always_comb begin
    out_ce = wr_out && (wen != '0);
    dir_ce = wr_dir && (wen != '0);
    out_d  = merge(out_q, wen, wval);
    dir_d  = merge(dir_q, wen, wval);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (out_ce) out_q <= out_d;
      if (dir_ce) dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d[s];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_bank_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PIN_W = NUM_HALVES * HALF_W,
  localparam int unsigned BUS_W = 2 * HALF_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_strobe,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic [NUM_HALVES-1:0][HALF_W-1:0] out_q,
  input  logic [NUM_HALVES-1:0][HALF_W-1:0] dir_q,
  input  logic [PIN_W-1:0]                  pins_sync,
  output logic [BUS_W-1:0]                  rdata
);
  reg_kind_e         kind;
  logic [HALF_W-1:0] half_word;
  logic [BUS_W-1:0]  rdata_d, rdata_q;

  always_comb begin
    kind      = KIND_NONE;
    half_word = '0;
    if (rd_addr == ADDR_INPUT) kind = KIND_INPUT;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (rd_addr == out_addr(h)) begin
        kind      = KIND_OUT;
        half_word = out_q[h];
      end
      if (rd_addr == dir_addr(h)) begin
        kind      = KIND_DIR;
        half_word = dir_q[h];
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_strobe) begin
      unique case (kind)
        KIND_INPUT:        rdata_d = BUS_W'(pins_sync);
        KIND_OUT, KIND_DIR: rdata_d = {{(BUS_W-HALF_W){1'b0}}, half_word};
        default:           rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_masked_bank.sv
module gpio_masked_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PIN_W = NUM_HALVES * HALF_W,
  localparam int unsigned BUS_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic                              rst_int_n;
  logic [NUM_HALVES-1:0]             wr_out, wr_dir;
  logic                              rd_strobe;
  logic [NUM_HALVES-1:0][HALF_W-1:0] out_q, dir_q;
  logic [PIN_W-1:0]                  pins_sync;
  logic [HALF_W-1:0]                 wen, wval;

  assign wen  = bus_wdata[BUS_W-1:HALF_W];
  assign wval = bus_wdata[HALF_W-1:0];

  gpio_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gpio_addr_decode u_dec (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_out    (wr_out),
    .wr_dir    (wr_dir),
    .rd_strobe (rd_strobe)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    gpio_half_regs #(.HALF_W(HALF_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr_out (wr_out[h]),
      .wr_dir (wr_dir[h]),
      .wen    (wen),
      .wval   (wval),
      .out_q  (out_q[h]),
      .dir_q  (dir_q[h])
    );
    assign pin_oe [h*HALF_W +: HALF_W] = dir_q[h];
    assign pin_out[h*HALF_W +: HALF_W] = dir_q[h] & out_q[h];
  end

  gpio_in_sync #(.WIDTH(PIN_W), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  gpio_readback #(.HALF_W(HALF_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_strobe (rd_strobe),
    .rd_addr   (bus_addr),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .pins_sync (pins_sync),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PIN_W = NUM_HALVES * HALF_W,
  localparam int unsigned BUS_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [PIN_W-1:0]  pin_in,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe
);
  logic [3:0] since_rst;
  logic       warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;
  end
  assign warm = (since_rst >= 4'd6);

  logic wr, rd;
  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (pin_oe == '0 && pin_out == '0 && bus_rdata == '0);
    end
  end

  a_r4_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(pin_oe) && $stable(pin_out)));

  a_r3_zero_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_wdata[BUS_W-1:HALF_W] == '0) |=> ($stable(pin_oe) && $stable(pin_out)));

  a_r8_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr == ADDR_INPUT || bus_addr > dir_addr(NUM_HALVES-1)))
      |=> ($stable(pin_oe) && $stable(pin_out)));

  a_r2_dir_lo_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && wr && bus_addr == dir_addr(0)) |=>
      ((pin_oe[HALF_W-1:0] & $past(bus_wdata[BUS_W-1:HALF_W])) ==
       ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[BUS_W-1:HALF_W]))) &&
      (((pin_oe[HALF_W-1:0] ^ $past(pin_oe[HALF_W-1:0])) &
        ~$past(bus_wdata[BUS_W-1:HALF_W])) == '0));

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr != ADDR_INPUT) |=> (bus_rdata[BUS_W-1:HALF_W] == '0));

  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));

  a_r7_input_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && rd && bus_addr == ADDR_INPUT) |=> (bus_rdata == BUS_W'($past(pin_in, 3))));
endmodule

bind gpio_masked_bank gpio_bank_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_masked_bank.sv
`timescale 1ns/1ps
module sim_gpio_masked_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe;

  always #2.5 clk = ~clk;

  gpio_masked_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int total = 0;
  int bad   = 0;
  logic [15:0] m_out [2];
  logic [15:0] m_dir [2];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] cur, input logic [31:0] w);
    return (cur & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] exp_oe();
    return {m_dir[1], m_dir[0]};
  endfunction

  function automatic logic [31:0] exp_out();
    return {m_dir[1] & m_out[1], m_dir[0] & m_out[0]};
  endfunction

  function automatic logic [31:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd1: return {16'h0, m_out[0]};
      3'd2: return {16'h0, m_dir[0]};
      3'd3: return {16'h0, m_out[1]};
      3'd4: return {16'h0, m_dir[1]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    case (a)
      3'd1: m_out[0] = merge(m_out[0], d);
      3'd2: m_dir[0] = merge(m_dir[0], d);
      3'd3: m_out[1] = merge(m_out[1], d);
      3'd4: m_dir[1] = merge(m_dir[1], d);
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_pins(input string req);
    chk({req, " pin_oe"},  pin_oe,  exp_oe());
    chk({req, " pin_out"}, pin_out, exp_out());
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] hold;
    void'($urandom(32'h5eed_1234));
    m_out[0] = '0; m_out[1] = '0; m_dir[0] = '0; m_dir[1] = '0;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pin_in = 32'h0;
    rst_n = 0;
    idle(3);
    chk("R1 oe in reset", pin_oe, 32'h0);
    chk("R1 out in reset", pin_out, 32'h0);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1;
    idle(6);
    for (int a = 1; a <= 4; a++) begin
      bus_read(3'(a), rd);
      chk("R1 register zero after reset", rd, 32'h0);
    end
    check_pins("R1");

    // R2 set then clear with enables; R5 low half mapping
    bus_write(3'd2, 32'h00FF_00FF); check_pins("R2 dir set");
    bus_write(3'd1, 32'h000F_000F); check_pins("R2 out set");
    chk("R5 low pin 3 driven", {31'h0, pin_out[3]}, 32'h1);
    bus_write(3'd1, 32'h0005_0000); check_pins("R2 enabled clear");
    bus_write(3'd2, 32'hF000_FFFF); check_pins("R2 sparse enable");
    // R5 high half: bit 2 -> pin 18
    bus_write(3'd4, 32'h0004_0004);
    bus_write(3'd3, 32'h0004_0004);
    chk("R5 pin 18 oe",  pin_oe,  {16'h0004, m_dir[0]});
    chk("R5 pin 18 out", {31'h0, pin_out[18]}, 32'h1);
    // R4 direction 0 releases pin
    bus_write(3'd3, 32'h0003_0003);
    chk("R4 input pin not driven", {30'h0, pin_out[17:16]}, 32'h0);
    // R3 zero enable
    hold = pin_oe;
    bus_write(3'd2, 32'h0000_FFFF);
    chk("R3 zero enable oe unchanged", pin_oe, hold);
    check_pins("R3");
    // R8 writes to input / unmapped
    bus_write(3'd0, 32'hFFFF_FFFF); check_pins("R8 input write");
    bus_write(3'd6, 32'hFFFF_FFFF); check_pins("R8 unmapped write");
    bus_read(3'd7, rd); chk("R8 unmapped read", rd, 32'h0);
    // R6 readback and hold
    bus_read(3'd2, rd); chk("R6 dir lo readback", rd, exp_reg(3'd2));
    idle(3);
    chk("R6 rdata held", bus_rdata, exp_reg(3'd2));

    // R7 latency: pin changes in same half-cycle as input read
    pin_in = 32'hA5A5_0F0F; idle(4);
    bus_read(3'd0, rd); chk("R7 stable level", rd, 32'hA5A5_0F0F);
    pin_in = 32'h1234_8001;
    bus_read(3'd0, rd); chk("R7 edge k+0 old level", rd, 32'hA5A5_0F0F);
    bus_read(3'd0, rd); chk("R7 edge k+1 old level", rd, 32'hA5A5_0F0F);
    bus_read(3'd0, rd); chk("R7 edge k+2 new level", rd, 32'h1234_8001);

    // random mix, R2 R3 R4 R5 R6 R8
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [2:0]  a;
      logic [31:0] d;
      op = $urandom % 4;
      a  = 3'($urandom % 8);
      d  = $urandom;
      case ($urandom % 4)
        0: d[31:16] = 16'h0;
        1: d[31:16] = 16'hFFFF;
        default: ;
      endcase
      pin_in = $urandom;
      if (op < 2) begin
        bus_write(a, d);
        check_pins("R2 random write");
      end else if (op == 2) begin
        if (a == 3'd0) a = 3'd1;
        bus_read(a, rd);
        chk("R6 random read", rd, exp_reg(a));
      end else begin
        hold = pin_in;
        idle(2);
        bus_read(3'd0, rd);
        chk("R7 random input read", rd, hold);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule